// File: doc/BRIEF.md
# Adaptive Frame Brightness Thresholder

This block turns a stream of greyscale pixels into a one-bit image. The cut level adapts to the scene from one frame to the next. As each frame passes through, the block keeps two statistics: the darkest pixel value seen so far, and the integer mean of all pixel values. It finds the mean without a hardware divider. When a frame completes, both figures are published together with a threshold that sits halfway between them.

Every pixel of the following frame is then compared against that threshold. The output is inverted, so pixels darker than the threshold come out as 1 and all others as 0. A downstream shadow or blob finder can use the marked dark regions directly.

Pixels arrive through a valid/ready handshake with a start-of-frame flag. The flag lets the source restart a frame at any point. The frame length in pixels is a fixed parameter. While the block finishes its mean after the final pixel of a frame, it holds `in_ready` low so that the next frame always sees the freshly published threshold.

Top module: `frame_binarizer`

## Requirements
- R1: After synchronous reset, `in_ready` is 1, `out_valid` and `out_bit` are 0, `stats_done` is 0, and `stat_min`, `stat_mean` and `stat_thresh` are all 0.
- R2: A pixel is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `out_valid` is 1 in exactly the cycle after each accepted pixel and 0 otherwise. `out_bit` is 0 whenever `out_valid` is 0.
- R3: For an accepted pixel p with active threshold T, `out_bit` is 1 when p < T and 0 when p >= T.
- R4: When a frame completes, `stat_min` becomes the smallest pixel value accepted in that frame.
- R5: When a frame completes, `stat_mean` becomes floor(sum of the frame's pixels / FRAME_PIXELS).
- R6: `stat_min`, `stat_mean` and `stat_thresh` change only in a cycle where `stats_done` is 1. In that cycle `stat_thresh` equals `stat_min` + ((`stat_mean` − `stat_min`) >> 1). `stats_done` is 1 for a single cycle per completed frame.
- R7: Each frame is binarized against the threshold published for the previous frame. Before the first frame completes, the threshold is 0, so every output bit is 0.
- R8: `in_ready` is 0 from the edge that accepts a frame's last pixel until the `stats_done` cycle. In the `stats_done` cycle `in_ready` is 1 again.
- R9: An accepted pixel with `in_sof` = 1 becomes pixel 0 of a new frame. Any partial frame before it is discarded and does not affect the statistics.
- R10: Cycles with `in_valid` = 0 do not count toward the frame length and do not alter the statistics.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel is present |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_pix | input | PIX_W | Greyscale pixel value |
| out_valid | output | 1 | `out_bit` carries a result |
| out_bit | output | 1 | 1 when the pixel was below the threshold |
| stat_min | output | PIX_W | Minimum of the last completed frame |
| stat_mean | output | PIX_W | Mean of the last completed frame |
| stat_thresh | output | PIX_W | Threshold applied to the current frame |
| stats_done | output | 1 | One-cycle pulse when new statistics are published |

## Verification
Each type of internal error shows up at the ports within about one frame.

- A wrong running minimum or a wrong quotient count appears in `stat_min` or `stat_mean` in the `stats_done` cycle that ends the same frame. It then changes individual `out_bit` values in the very next frame.
- A drain that stops too early or runs too long moves the pulse on `stats_done` and shortens or stretches the `in_ready` gap. The mean is also off.
- A frame counter that loses track, either through a mishandled start-of-frame or by counting idle cycles, shifts the frame boundary. The published figures then come from the wrong pixels.

// File: rtl/frame_binarizer_pkg.sv
package frame_binarizer_pkg;

  // Quotient engine phases
  typedef enum logic [0:0] {
    QE_GATHER = 1'b0,
    QE_DRAIN  = 1'b1
  } qe_phase_t;

  // Halfway point between a low and a high value, truncated
  function automatic int unsigned mid_floor(input int unsigned lo, input int unsigned hi);
    return lo + ((hi - lo) >> 1);
  endfunction

endpackage

// File: rtl/fb_min_track.sv
module fb_min_track #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             first,
  input  logic             last,
  input  logic [PIX_W-1:0] pix,
  output logic [PIX_W-1:0] frame_min
);
  localparam logic [PIX_W-1:0] PIX_MAX = {PIX_W{1'b1}};

  logic [PIX_W-1:0] run_min;
  logic [PIX_W-1:0] cand;

  // The first pixel of a frame restarts the search
  always_comb begin
    if (first)
      cand = pix;
    else if (pix < run_min)
      cand = pix;
    else
      cand = run_min;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_min   <= PIX_MAX;
      frame_min <= '0;
    end else if (take) begin
      if (last) begin
        frame_min <= cand;
        run_min   <= PIX_MAX;
      end else begin
        run_min <= cand;
      end
    end
  end
endmodule

// File: rtl/fb_mean_div.sv
module fb_mean_div
  import frame_binarizer_pkg::*;
#(
  parameter int PIX_W        = 8,
  parameter int FRAME_PIXELS = 76800
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             first,
  input  logic             last,
  input  logic [PIX_W-1:0] pix,
  output logic             busy,
  output logic             done,
  output logic [PIX_W-1:0] mean
);
  localparam int CNT_W = $clog2(FRAME_PIXELS + 1);
  localparam int ACC_W = PIX_W + CNT_W;
  localparam logic [ACC_W-1:0] DIVISOR = ACC_W'(FRAME_PIXELS);

  qe_phase_t        phase;
  logic [ACC_W-1:0] acc;
  logic [PIX_W-1:0] quo;
  logic [ACC_W-1:0] base_acc;
  logic [PIX_W-1:0] base_quo;
  logic             can_sub;

  assign busy     = (phase == QE_DRAIN);
  assign base_acc = first ? '0 : acc;
  assign base_quo = first ? '0 : quo;
  assign can_sub  = (base_acc >= DIVISOR);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= QE_GATHER;
      acc   <= '0;
      quo   <= '0;
      mean  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == QE_DRAIN) begin
        if (acc >= DIVISOR) begin
          acc <= acc - DIVISOR;
          quo <= quo + PIX_W'(1);
        end else begin
          mean  <= quo;
          done  <= 1'b1;
          acc   <= '0;
          quo   <= '0;
          phase <= QE_GATHER;
        end
      end else if (take) begin
        // Add the pixel and take off one divisor if the sum allows it
        acc <= base_acc + {{(ACC_W-PIX_W){1'b0}}, pix} - (can_sub ? DIVISOR : '0);
        quo <= base_quo + (can_sub ? PIX_W'(1) : '0);
        if (last)
          phase <= QE_DRAIN;
      end
    end
  end
endmodule

// File: rtl/fb_binarize.sv
module fb_binarize
  import frame_binarizer_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             publish,
  input  logic [PIX_W-1:0] new_min,
  input  logic [PIX_W-1:0] new_mean,
  input  logic             take,
  input  logic [PIX_W-1:0] pix,
  output logic [PIX_W-1:0] stat_min,
  output logic [PIX_W-1:0] stat_mean,
  output logic [PIX_W-1:0] stat_thresh,
  output logic             stats_done,
  output logic             out_valid,
  output logic             out_bit
);
  logic [PIX_W-1:0] next_thr;

  assign next_thr = PIX_W'(mid_floor(int'(new_min), int'(new_mean)));

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_min    <= '0;
      stat_mean   <= '0;
      stat_thresh <= '0;
      stats_done  <= 1'b0;
      out_valid   <= 1'b0;
      out_bit     <= 1'b0;
    end else begin
      stats_done <= publish;
      if (publish) begin
        stat_min    <= new_min;
        stat_mean   <= new_mean;
        stat_thresh <= next_thr;
      end
      out_valid <= take;
      out_bit   <= take && (pix < stat_thresh);
    end
  end
endmodule

// File: rtl/frame_binarizer.sv
module frame_binarizer #(
  parameter int PIX_W        = 8,
  parameter int FRAME_PIXELS = 76800
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sof,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  output logic             out_bit,
  output logic [PIX_W-1:0] stat_min,
  output logic [PIX_W-1:0] stat_mean,
  output logic [PIX_W-1:0] stat_thresh,
  output logic             stats_done
);
  localparam int CNT_W = $clog2(FRAME_PIXELS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_PIXELS - 1);

  logic             take;
  logic             last;
  logic [CNT_W-1:0] pix_cnt;
  logic             div_busy;
  logic             div_done;
  logic [PIX_W-1:0] div_mean;
  logic [PIX_W-1:0] frame_min;

  // Stay closed while draining and for the publish cycle
  assign in_ready = !div_busy && !div_done;
  assign take     = in_valid && in_ready;
  assign last     = in_sof ? (FRAME_PIXELS == 1) : (pix_cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst)
      pix_cnt <= '0;
    else if (take) begin
      if (last)
        pix_cnt <= '0;
      else if (in_sof)
        pix_cnt <= CNT_W'(1);
      else
        pix_cnt <= pix_cnt + CNT_W'(1);
    end
  end

  fb_min_track #(.PIX_W(PIX_W)) u_min (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .first     (in_sof),
    .last      (last),
    .pix       (in_pix),
    .frame_min (frame_min)
  );

  fb_mean_div #(.PIX_W(PIX_W), .FRAME_PIXELS(FRAME_PIXELS)) u_div (
    .clk   (clk),
    .rst   (rst),
    .take  (take),
    .first (in_sof),
    .last  (last),
    .pix   (in_pix),
    .busy  (div_busy),
    .done  (div_done),
    .mean  (div_mean)
  );

  fb_binarize #(.PIX_W(PIX_W)) u_bin (
    .clk         (clk),
    .rst         (rst),
    .publish     (div_done),
    .new_min     (frame_min),
    .new_mean    (div_mean),
    .take        (take),
    .pix         (in_pix),
    .stat_min    (stat_min),
    .stat_mean   (stat_mean),
    .stat_thresh (stat_thresh),
    .stats_done  (stats_done),
    .out_valid   (out_valid),
    .out_bit     (out_bit)
  );
endmodule

// File: rtl/frame_binarizer_chk.sv
module frame_binarizer_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_bit,
  input logic [PIX_W-1:0] stat_min,
  input logic [PIX_W-1:0] stat_mean,
  input logic [PIX_W-1:0] stat_thresh,
  input logic             stats_done
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R2
  bit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_bit);

  // R2
  out_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (out_valid == $past(in_valid && in_ready)));

  // R6
  thresh_between_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_min <= stat_thresh) && (stat_thresh <= stat_mean));

  // R6
  stats_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !stats_done) |-> ($stable(stat_thresh) && $stable(stat_min) && $stable(stat_mean)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    stats_done |=> !stats_done);

  // R8
  ready_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $rose(stats_done)) |-> !$past(in_ready));
endmodule

bind frame_binarizer frame_binarizer_chk #(.PIX_W(PIX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_bit     (out_bit),
  .stat_min    (stat_min),
  .stat_mean   (stat_mean),
  .stat_thresh (stat_thresh),
  .stats_done  (stats_done)
);

// File: tb/sim_frame_binarizer.sv
module sim_frame_binarizer;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int NPIX = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_sof = 1'b0;
  logic [PW-1:0] in_pix = '0;
  logic          in_ready, out_valid, out_bit, stats_done;
  logic [PW-1:0] stat_min, stat_mean, stat_thresh;

  int n_checks = 0;
  int n_fail   = 0;
  int model_thr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_binarizer #(.PIX_W(PW), .FRAME_PIXELS(NPIX)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_pix(in_pix), .out_valid(out_valid), .out_bit(out_bit),
    .stat_min(stat_min), .stat_mean(stat_mean), .stat_thresh(stat_thresh),
    .stats_done(stats_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Offer one pixel, wait for acceptance, check the registered result
  task automatic send_pix(input int val, input bit sof, input string req);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_sof   = sof;
    in_pix   = PW'(val);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_sof   = 1'b0;
    check(out_valid == 1'b1, "R2 out_valid after accept", int'(out_valid), 1);
    check(out_bit == (val < model_thr), req, int'(out_bit), int'(val < model_thr));
  endtask

  task automatic wait_stats(input int emin, input int emean);
    bit closed_ok = 1'b1;
    bit seen = 1'b0;
    int ethr;
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk);
      #1;
      if (stats_done) begin seen = 1'b1; break; end
      if (in_ready) closed_ok = 1'b0;
    end
    check(seen, "R6 stats_done pulse", int'(seen), 1);
    check(closed_ok, "R8 ready low while draining", int'(closed_ok), 1);
    check(in_ready == 1'b1, "R8 ready back with stats_done", int'(in_ready), 1);
    ethr = emin + ((emean - emin) >> 1);
    check(int'(stat_min) == emin, "R4 frame minimum", int'(stat_min), emin);
    check(int'(stat_mean) == emean, "R5 frame mean", int'(stat_mean), emean);
    check(int'(stat_thresh) == ethr, "R6 threshold", int'(stat_thresh), ethr);
    model_thr = ethr;
    @(posedge clk);
    #1;
    check(stats_done == 1'b0, "R6 single-cycle pulse", int'(stats_done), 0);
  endtask

  task automatic send_frame(input int px[NPIX], input bit gaps, input string req);
    int mn = 255;
    int sum = 0;
    for (int i = 0; i < NPIX; i++) begin
      send_pix(px[i], i == 0, req);
      if (px[i] < mn) mn = px[i];
      sum += px[i];
      if (i == NPIX-1)
        check(in_ready == 1'b0, "R8 ready drops after last pixel", int'(in_ready), 0);
      else if (gaps) begin
        @(posedge clk);
        #1;
        check(out_valid == 1'b0 && out_bit == 1'b0, "R2 R10 idle cycle quiet",
              int'(out_valid), 0);
        @(posedge clk);
      end
    end
    wait_stats(mn, sum / NPIX);
  endtask

  task automatic t_reset();
    check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0 && out_bit == 1'b0, "R1 output idle", int'(out_valid), 0);
    check(stat_min == 0 && stat_mean == 0 && stat_thresh == 0, "R1 stats zero",
          int'(stat_thresh), 0);
    check(stats_done == 1'b0, "R1 no pulse", int'(stats_done), 0);
  endtask

  task automatic t_first_frame();
    // Threshold 0 before any statistics: every bit 0
    send_frame('{100, 50, 200, 30, 90, 70, 255, 5}, 1'b0, "R7 first frame all zero");
  endtask

  task automatic t_inverted();
    // Threshold 52 from the previous frame; mean 69.5 truncates to 69
    send_frame('{51, 52, 0, 255, 60, 40, 45, 53}, 1'b0, "R3 R7 inverted compare");
  endtask

  task automatic t_sof_restart();
    // Partial frame of dark pixels must not reach the statistics
    for (int i = 0; i < 3; i++) send_pix(0, 1'b0, "R3 partial frame output");
    send_frame('{200, 200, 200, 200, 200, 200, 200, 200}, 1'b0, "R9 restart frame");
  endtask

  task automatic t_gaps();
    send_frame('{255, 255, 255, 255, 255, 255, 255, 255}, 1'b1, "R10 frame with gaps");
  endtask

  task automatic t_top_threshold();
    // Threshold 255: only 255 maps to 0
    send_frame('{254, 255, 0, 128, 1, 2, 3, 4}, 1'b0, "R3 threshold at maximum");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first_frame();
    t_inverted();
    t_sof_restart();
    t_gaps();
    t_top_threshold();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule